// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from five peripheral sources of a small 8-bit processor and turns them into one request line plus a vector address. Each source owns one bit in a request-latch register and one bit in a mask register. Both registers sit on a byte-wide register bus. A peripheral raises its request with a single-cycle pulse, and the pulse latches the matching bit. The processor can also read and overwrite the latched bits over the bus.

A source counts as pending only when its latched bit and its mask bit are both set. A global delivery switch is not on the bus. The processor sets and clears it with two strobes. While the switch is on and anything is pending, the request line is high and the vector output carries the entry address of the most urgent pending source. The processor checks the request line between instructions. When it takes the interrupt, it pulses the acknowledge input. That clears the latched bit of the source on offer in that cycle and turns the delivery switch off, so a second interrupt cannot nest until software turns it back on.

Source bit order, from most to least urgent, is: bit 0 frame-end, bit 1 display status, bit 2 timer, bit 3 serial link, bit 4 keypad.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the latched bits, the mask register and the delivery switch are all zero. The request line is low and the vector output is 0x00.
- R2: The latch register is at bus address 0xFF0F. A bus write there loads bits 4..0 from write data bits 4..0. A read returns the five latched bits in bits 4..0, with bits 7..5 reading as 1.
- R3: The mask register is at bus address 0xFFFF and holds all 8 written bits. A read there returns them unchanged. Any other address reads 0x00, and writes to it change no state.
- R4: The request line is high exactly when the delivery switch is on and at least one bit is set in both the latch register and bits 4..0 of the mask register.
- R5: When several sources are pending, the lowest bit number wins. The vector output is 0x40 + 8 × (winning bit), giving 0x40, 0x48, 0x50, 0x58, 0x60. The vector output is 0x00 while the request line is low.
- R6: A request pulse on input bit n sets latched bit n at the next clock edge. This holds even when a bus write to 0xFF0F in the same cycle writes 0 to that bit.
- R7: An acknowledge in a cycle with the request line high clears only the winning source's latched bit and turns the delivery switch off. An acknowledge while the request line is low changes nothing.
- R8: The set strobe turns the delivery switch on. The clear strobe turns it off. When both strobes arrive in the same cycle the clear wins, and an accepted acknowledge also wins over a same-cycle set strobe.
- R9: When a request pulse for the winning source arrives in the same cycle as its acknowledge, that source's latched bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_we | input | 1 | Register bus write strobe |
| bus_rdata | output | 8 | Register bus read data (combinational on address) |
| irq_req_i | input | 5 | Single-cycle request pulses, one per source |
| ime_set_i | input | 1 | Turn delivery switch on |
| ime_clr_i | input | 1 | Turn delivery switch off |
| irq_ack_i | input | 1 | Processor takes the offered interrupt |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_vec_o | output | 8 | Entry address of the winning source |

## Verification
The hardest situation to reach from the ports is one clock edge where three updates land on the latch register together. These are an accepted acknowledge, a request pulse for the very source being acknowledged, and a bus write to 0xFF0F. The directed phase builds each pairing of these on purpose. The random phase draws acknowledge, set strobe, request bits and writes aimed at the two register addresses at high enough rates that all three coincide many times. It also checks every cycle against a reference model that applies the updates in the required order.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [2:0] {
      SRC_FRAME  = 3'd0,
      SRC_DISP   = 3'd1,
      SRC_TIMER  = 3'd2,
      SRC_LINK   = 3'd3,
      SRC_KEYPAD = 3'd4
   } irq_src_e;

   localparam int unsigned IRQ_SRC_COUNT = 5;
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile #(
   parameter int unsigned NUM_SRC = 5,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 16'hFFFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic               bus_we,
   input  logic [NUM_SRC-1:0] set_mask,
   input  logic [NUM_SRC-1:0] clr_mask,
   output logic [DATA_W-1:0]  rd_data,
   output logic [NUM_SRC-1:0] flag_q,
   output logic [NUM_SRC-1:0] pend
);
   localparam int unsigned PAD_W = DATA_W - NUM_SRC;

   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_width
      $error("irq_regfile: NUM_SRC must lie in 1..DATA_W");
   end
   if (FLAG_ADDR == MASK_ADDR) begin : g_bad_addr
      $error("irq_regfile: register addresses must differ");
   end

   logic               hit_flag;
   logic               hit_mask;
   logic [NUM_SRC-1:0] flag_base;
   logic [NUM_SRC-1:0] flag_d;
   logic [DATA_W-1:0]  mask_q;
   logic [DATA_W-1:0]  flag_view;

   assign hit_flag = (bus_addr == FLAG_ADDR);
   assign hit_mask = (bus_addr == MASK_ADDR);

   // order: bus write, then acknowledge clear, then peripheral set
   always_comb begin
      flag_base = (bus_we && hit_flag) ? bus_wdata[NUM_SRC-1:0] : flag_q;
      flag_d    = (flag_base & ~clr_mask) | set_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= '0;
         mask_q <= '0;
      end else begin
         flag_q <= flag_d;
         if (bus_we && hit_mask) begin
            mask_q <= bus_wdata;
         end
      end
   end

   if (PAD_W > 0) begin : g_pad
      assign flag_view = {{PAD_W{1'b1}}, flag_q};
   end else begin : g_nopad
      assign flag_view = flag_q;
   end

   always_comb begin
      if (hit_flag) begin
         rd_data = flag_view;
      end else if (hit_mask) begin
         rd_data = mask_q;
      end else begin
         rd_data = '0;
      end
   end

   assign pend = flag_q & mask_q[NUM_SRC-1:0];
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int unsigned NUM_SRC    = 5,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VEC_BASE   = 'h40,
   parameter int unsigned VEC_STRIDE = 8
) (
   input  logic [NUM_SRC-1:0] pend,
   output logic               any,
   output logic [NUM_SRC-1:0] grant,
   output logic [VEC_W-1:0]   vec
);
   localparam int unsigned VEC_TOP = VEC_BASE + (NUM_SRC - 1) * VEC_STRIDE;

   if (VEC_TOP >= (1 << VEC_W)) begin : g_bad_vec
      $error("irq_prio_arb: vector table does not fit VEC_W");
   end

   logic [NUM_SRC:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
      assign grant[i]  = pend[i] & ~seen[i];
      assign seen[i+1] = seen[i] | pend[i];
   end

   assign any = seen[NUM_SRC];

   always_comb begin
      vec = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (grant[i]) begin
            vec = vec | VEC_W'(VEC_BASE + i * VEC_STRIDE);
         end
      end
   end
endmodule

// File: rtl/irq_master.sv
module irq_master (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic take_i,
   output logic ime_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ime_q <= 1'b0;
      end else if (clr_i || take_i) begin
         ime_q <= 1'b0;
      end else if (set_i) begin
         ime_q <= 1'b1;
      end
   end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned NUM_SRC    = IRQ_SRC_COUNT,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VEC_BASE   = 'h40,
   parameter int unsigned VEC_STRIDE = 8,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 16'hFFFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic               bus_we,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] irq_req_i,
   input  logic               ime_set_i,
   input  logic               ime_clr_i,
   input  logic               irq_ack_i,
   output logic               irq_o,
   output logic [VEC_W-1:0]   irq_vec_o
);
   logic [NUM_SRC-1:0] flag_q;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] grant;
   logic [NUM_SRC-1:0] clr_mask;
   logic [VEC_W-1:0]   arb_vec;
   logic               any_pend;
   logic               ime_q;
   logic               take;

   irq_regfile #(
      .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .FLAG_ADDR(FLAG_ADDR), .MASK_ADDR(MASK_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
      .set_mask(irq_req_i), .clr_mask(clr_mask),
      .rd_data(bus_rdata), .flag_q(flag_q), .pend(pend)
   );

   irq_prio_arb #(
      .NUM_SRC(NUM_SRC), .VEC_W(VEC_W),
      .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
   ) u_arb (
      .pend(pend), .any(any_pend), .grant(grant), .vec(arb_vec)
   );

   irq_master u_ime (
      .clk(clk), .rst_n(rst_n),
      .set_i(ime_set_i), .clr_i(ime_clr_i), .take_i(take),
      .ime_q(ime_q)
   );

   assign irq_o     = ime_q & any_pend;
   assign take      = irq_ack_i & irq_o;
   assign clr_mask  = take ? grant : '0;
   assign irq_vec_o = irq_o ? arb_vec : '0;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
   parameter int unsigned NUM_SRC = 5,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_we,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic [NUM_SRC-1:0] irq_req_i,
   input logic               ime_clr_i,
   input logic               irq_ack_i,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] flag_q,
   input logic [NUM_SRC-1:0] grant,
   input logic               ime_q
);
   a_r2_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == FLAG_ADDR) |-> (&bus_rdata[DATA_W-1:NUM_SRC]));

   a_r4_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ime_q);

   a_r5_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($countones(grant) == 1));

   a_r6_request_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req_i != '0) |=> ((flag_q & $past(irq_req_i)) == $past(irq_req_i)));

   a_r7_ack_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack_i && irq_o) |=> !ime_q);

   a_r7_ack_clears_winner: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack_i && irq_o && ((grant & irq_req_i) == '0)
       && !(bus_we && bus_addr == FLAG_ADDR))
      |=> ((flag_q & $past(grant)) == '0));

   a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ime_clr_i |=> !ime_q);
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
   .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_rdata(bus_rdata), .irq_req_i(irq_req_i), .ime_clr_i(ime_clr_i),
   .irq_ack_i(irq_ack_i), .irq_o(irq_o), .flag_q(flag_q), .grant(grant),
   .ime_q(ime_q)
);

// File: tb/irq_vec_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vec_ctrl_bench;
   localparam logic [15:0] A_FLAG = 16'hFF0F;
   localparam logic [15:0] A_MASK = 16'hFFFF;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic        bus_we;
   logic [7:0]  bus_rdata;
   logic [4:0]  irq_req_i;
   logic        ime_set_i, ime_clr_i, irq_ack_i;
   logic        irq_o;
   logic [7:0]  irq_vec_o;

   int n_vec  = 0;
   int n_fail = 0;

   // reference state
   logic [4:0] m_flag;
   logic [7:0] m_mask;
   logic       m_ime;

   irq_vec_ctrl u_irq_vec_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_req_i(irq_req_i),
      .ime_set_i(ime_set_i), .ime_clr_i(ime_clr_i), .irq_ack_i(irq_ack_i),
      .irq_o(irq_o), .irq_vec_o(irq_vec_o)
   );

   always #5 clk = ~clk;

   function automatic logic [4:0] f_pend();
      return m_flag & m_mask[4:0];
   endfunction

   function automatic logic f_irq();
      return m_ime && (f_pend() != 5'd0);
   endfunction

   function automatic logic [4:0] f_win();
      logic [4:0] p = f_pend();
      for (int i = 0; i < 5; i++) if (p[i]) return 5'(1 << i);
      return 5'd0;
   endfunction

   function automatic logic [7:0] f_vec();
      logic [4:0] p = f_pend();
      if (!f_irq()) return 8'h00;
      for (int i = 0; i < 5; i++) if (p[i]) return 8'(8'h40 + 8 * i);
      return 8'h00;
   endfunction

   function automatic logic [7:0] f_rd(logic [15:0] a);
      if (a == A_FLAG) return {3'b111, m_flag};
      if (a == A_MASK) return m_mask;
      return 8'h00;
   endfunction

   task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic compare_all();
      check("R4 request line", 16'(irq_o), 16'(f_irq()));
      check("R5 vector", 16'(irq_vec_o), 16'(f_vec()));
      check((bus_addr == A_FLAG) ? "R2 latch read" : "R3 mask/other read",
            16'(bus_rdata), 16'(f_rd(bus_addr)));
   endtask

   // drive at negedge, compare, clock, update model, return idle
   task automatic drive(logic [15:0] a, logic [7:0] w, logic we, logic [4:0] rq,
                        logic ak, logic st, logic cl);
      logic [4:0] base;
      logic       tk;
      bus_addr = a; bus_wdata = w; bus_we = we; irq_req_i = rq;
      irq_ack_i = ak; ime_set_i = st; ime_clr_i = cl;
      #1;
      compare_all();
      tk   = ak && f_irq();
      base = (we && a == A_FLAG) ? w[4:0] : m_flag;
      if (tk) base = base & ~f_win();
      base = base | rq;
      @(posedge clk);
      m_flag = base;
      if (we && a == A_MASK) m_mask = w;
      if (cl || tk) m_ime = 1'b0;
      else if (st) m_ime = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; irq_req_i = '0; irq_ack_i = 1'b0;
      ime_set_i = 1'b0; ime_clr_i = 1'b0;
   endtask

   task automatic peek(string tag, logic [15:0] a, logic [7:0] exp);
      bus_addr = a;
      #1;
      check(tag, 16'(bus_rdata), 16'(exp));
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
      irq_req_i = '0; ime_set_i = 1'b0; ime_clr_i = 1'b0; irq_ack_i = 1'b0;
      m_flag = '0; m_mask = '0; m_ime = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      peek("R1 latch after reset", A_FLAG, 8'hE0);
      peek("R1 mask after reset", A_MASK, 8'h00);
      check("R1 request low", 16'(irq_o), 16'd0);
      check("R1 vector zero", 16'(irq_vec_o), 16'h00);

      drive(A_MASK, 8'hFF, 1, 0, 0, 0, 0);
      drive(A_FLAG, 8'h1F, 1, 0, 0, 0, 0);
      check("R4 no request with master off", 16'(irq_o), 16'd0);
      drive(A_FLAG, 0, 0, 0, 0, 1, 0);
      check("R5 frame-end wins", 16'(irq_vec_o), 16'h40);
      drive(A_FLAG, 0, 0, 0, 1, 0, 0);
      peek("R7 ack clears bit0 only", A_FLAG, 8'hFE);
      check("R7 ack drops master", 16'(irq_o), 16'd0);
      drive(A_FLAG, 0, 0, 0, 0, 1, 0);
      check("R5 display next", 16'(irq_vec_o), 16'h48);
      drive(A_MASK, 8'h10, 1, 0, 0, 0, 0);
      check("R5 keypad vector under mask", 16'(irq_vec_o), 16'h60);
      drive(A_FLAG, 0, 0, 0, 1, 0, 0);
      peek("R7 ack clears keypad only", A_FLAG, 8'hEE);
      drive(A_FLAG, 0, 0, 0, 1, 0, 0);
      peek("R7 ack ignored when idle", A_FLAG, 8'hEE);
      drive(A_FLAG, 8'h00, 1, 5'b00100, 0, 0, 0);
      peek("R6 request beats write", A_FLAG, 8'hE4);
      drive(A_MASK, 8'hFF, 1, 0, 0, 1, 0);
      check("R5 timer vector", 16'(irq_vec_o), 16'h50);
      drive(A_FLAG, 0, 0, 5'b00100, 1, 0, 0);
      peek("R9 request beats ack", A_FLAG, 8'hE4);
      check("R9 master dropped", 16'(irq_o), 16'd0);
      drive(A_FLAG, 0, 0, 0, 0, 1, 1);
      check("R8 clear beats set", 16'(irq_o), 16'd0);
      drive(A_FLAG, 0, 0, 0, 0, 1, 0);
      check("R8 set strobe", 16'(irq_o), 16'd1);
      drive(A_FLAG, 0, 0, 0, 1, 1, 0);
      check("R8 ack beats set", 16'(irq_o), 16'd0);
      peek("R7 timer cleared", A_FLAG, 8'hE0);
      drive(16'hFF10, 8'hAA, 1, 0, 0, 0, 0);
      peek("R3 other address reads zero", 16'hFF10, 8'h00);
      peek("R3 mask unchanged", A_MASK, 8'hFF);
      drive(A_MASK, 8'h5A, 1, 0, 0, 0, 0);
      peek("R3 mask full width", A_MASK, 8'h5A);

      for (int k = 0; k < 4000; k++) begin
         logic [15:0] a;
         logic [4:0]  rq;
         case ($urandom_range(3))
            0: a = A_FLAG;
            1: a = A_MASK;
            2: a = 16'hFF80;
            default: a = 16'($urandom);
         endcase
         for (int b = 0; b < 5; b++) rq[b] = ($urandom_range(7) == 0);
         drive(a, 8'($urandom), ($urandom_range(3) == 0), rq,
               ($urandom_range(3) == 0), ($urandom_range(2) == 0),
               ($urandom_range(15) == 0));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule